// File: doc/BRIEF.md
# Multi-output PWM edge steering

This block drives eight PWM pins from one shared switching-period counter. Each pin has a programmed turn-on time and a programmed turn-off time, both measured in counter ticks. An eight-bit settings byte for each pin chooses which of three channel modulation inputs moves its edges. The same byte sets whether each edge moves and in which direction, and whether the pin's waveform is shifted by half a switching period.

A control loop outside the block supplies one signed modulation value for each channel. A pin assigned to the soft-started variant of channel C stays quiet until the soft-start-done flag is raised. A separate mask turns any pin off at once, and the pin's internal level keeps running so it can resume cleanly. The period, the edge times, the settings and the modulation values are captured together at the end of each period, so no period ever mixes old and new values.

Top module: `pwm_steer`

## Requirements
- R1: A counter steps from 0 to P-1 and restarts at 0, where P is the captured period. When P is 0 or 1, the counter stays at 0. The time between successive turn-on edges of a pin equals P cycles.
- R2: A pin's level is set in the cycle after the counter equals its effective rise time. It is cleared in the cycle after the counter equals its effective fall time. When both times match in the same cycle, the clear wins. Otherwise the level holds. After reset the counter is 0 and every level is low.
- R3: Settings byte layout: bit 7 = half-period shift; bits [6:5] = channel (00 A, 01 B, 10 C gated by soft start, 11 C not gated); bit 4 = modulation allow; bit 3 = rise modulation on; bit 2 = rise direction; bit 1 = fall modulation on; bit 0 = fall direction. Channel A uses modulation lane 0, B uses lane 1 and C uses lane 2, each lane MOD_W bits wide and signed.
- R4: The effective time of an edge is its programmed time plus a signed offset. When bit 4 or that edge's own enable is 0, the offset is 0. A direction bit of 0 adds the modulation value and moves the edge later. A direction bit of 1 subtracts it and moves the edge earlier.
- R5: If the sum of the programmed time and the offset is negative, it becomes 0. The final value is then reduced modulo P, with P taken as 1 when it is 0.
- R6: With bit 7 set, floor(P/2) is added to both edge times after the clamp and before the modulo. The pin's waveform then trails an unshifted copy by floor(P/2) cycles.
- R7: Setting bit n of the disable mask forces pin n low in the same cycle, with no register in the path. The pin's internal level keeps following its edges while it is disabled.
- R8: A pin whose captured channel code is 10 is held low while the soft-start-done flag is low. A pin with code 11 is never held by that flag.
- R9: The period, the edge times, the settings and the modulation lanes are captured only in the cycle where the counter restarts. A change at any other time takes effect at the next period.
- R10: While reset is asserted, all pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Switching period in counter ticks |
| rise_i | input | NUM_OUT*CNT_W | Programmed turn-on time for each pin; pin n uses slice n |
| fall_i | input | NUM_OUT*CNT_W | Programmed turn-off time for each pin; pin n uses slice n |
| cfg_i | input | NUM_OUT*8 | Settings byte for each pin; pin n uses byte n |
| pin_off_i | input | NUM_OUT | Disable mask; bit n forces pin n low |
| mod_i | input | 3*MOD_W | Signed modulation lanes for channels A, B and C |
| ss_done_i | input | 1 | Soft-start-done flag for channel C |
| pwm_o | output | NUM_OUT | PWM pins |

## Verification
Several properties are checked on every cycle. The counter stays below the captured period and restarts in the right place. The captured period and settings stay fixed between restarts. An edge hit moves a pin's level one cycle later, and with no hit the level holds. A disabled pin is always low, and a gated channel-C pin is low while soft start is unfinished.

The arithmetic can only be shown by the bench's scenarios, which run a behavioural model alongside the design. These cover the direction of modulation, which channel lane each pin uses, the clamp at zero, the wrap past the period end, the half-period shift and the deferred capture of changes made mid-period.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  typedef enum logic [1:0] {
    CH_A       = 2'b00,
    CH_B       = 2'b01,
    CH_C_GATED = 2'b10,
    CH_C_FREE  = 2'b11
  } chan_sel_e;

  // bit 7 down to bit 0 of the settings byte
  typedef struct packed {
    logic      half_shift;
    chan_sel_e chan;
    logic      bal_en;
    logic      rise_mod_en;
    logic      rise_neg;
    logic      fall_mod_en;
    logic      fall_neg;
  } out_cfg_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, per_q;

  // restart after the last tick; a period of 0 or 1 restarts every cycle
  assign wrap_o = (per_q <= CNT_W'(1)) || (cnt_q == per_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      per_q <= period_i;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int MOD_W  = 8,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrap_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        per_i,
  input  logic [CNT_W-1:0]        rise_i,
  input  logic [CNT_W-1:0]        fall_i,
  input  logic [7:0]              cfg_i,
  input  logic [NUM_CH*MOD_W-1:0] mod_i,
  output logic                    lvl_o,
  output logic                    rise_hit_o,
  output logic                    fall_hit_o,
  output logic                    gated_o,
  output logic [7:0]              cfg_sh_o
);
  localparam int SW = CNT_W + 2;

  out_cfg_t               cfg_sh;
  logic [CNT_W-1:0]       rise_sh, fall_sh, rise_eff, fall_eff;
  logic [1:0]             ch_idx;
  logic signed [MOD_W-1:0] m_sel;

  // programmed time + signed offset, clamped at zero, optional half shift, modulo period
  function automatic logic [CNT_W-1:0] eff_time(
    input logic [CNT_W-1:0]        base,
    input logic                    mod_on,
    input logic                    neg,
    input logic signed [MOD_W-1:0] m,
    input logic                    half,
    input logic [CNT_W-1:0]        per
  );
    logic signed [SW-1:0] mx, d, s;
    logic [SW-1:0]        pm, r;
    mx = SW'(m);
    d  = mod_on ? (neg ? -mx : mx) : '0;
    s  = $signed({2'b00, base}) + d;
    if (s < 0) s = '0;
    if (half) s = s + $signed({2'b00, per >> 1});
    pm = (per == '0) ? SW'(1) : {2'b00, per};
    r  = $unsigned(s) % pm;
    return r[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_sh <= '0;
      fall_sh <= '0;
      cfg_sh  <= '0;
    end else if (wrap_i) begin
      rise_sh <= rise_i;
      fall_sh <= fall_i;
      cfg_sh  <= out_cfg_t'(cfg_i);
    end
  end

  assign ch_idx = cfg_sh.chan[1] ? 2'd2 : {1'b0, cfg_sh.chan[0]};
  assign m_sel  = $signed(mod_i[ch_idx*MOD_W +: MOD_W]);

  assign rise_eff = eff_time(rise_sh, cfg_sh.bal_en & cfg_sh.rise_mod_en,
                             cfg_sh.rise_neg, m_sel, cfg_sh.half_shift, per_i);
  assign fall_eff = eff_time(fall_sh, cfg_sh.bal_en & cfg_sh.fall_mod_en,
                             cfg_sh.fall_neg, m_sel, cfg_sh.half_shift, per_i);

  assign rise_hit_o = (cnt_i == rise_eff);
  assign fall_hit_o = (cnt_i == fall_eff);

  always_ff @(posedge clk) begin
    if (!rst_n)          lvl_o <= 1'b0;
    else if (fall_hit_o) lvl_o <= 1'b0;
    else if (rise_hit_o) lvl_o <= 1'b1;
  end

  assign gated_o  = (cfg_sh.chan == CH_C_GATED);
  assign cfg_sh_o = cfg_sh;
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
  parameter int NUM_OUT = 8,
  parameter int CNT_W   = 12,
  parameter int MOD_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [NUM_OUT*CNT_W-1:0] rise_i,
  input  logic [NUM_OUT*CNT_W-1:0] fall_i,
  input  logic [NUM_OUT*8-1:0]     cfg_i,
  input  logic [NUM_OUT-1:0]       pin_off_i,
  input  logic [3*MOD_W-1:0]       mod_i,
  input  logic                     ss_done_i,
  output logic [NUM_OUT-1:0]       pwm_o
);
  localparam int NUM_CH = 3;

  logic                      wrap;
  logic [CNT_W-1:0]          cnt, per_sh;
  logic [NUM_CH*MOD_W-1:0]   mod_sh;
  logic [NUM_OUT-1:0]        lvl, rise_hit, fall_hit, gated;
  logic [NUM_OUT*8-1:0]      cfg_sh_flat;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .cnt_o    (cnt),
    .per_o    (per_sh),
    .wrap_o   (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    mod_sh <= '0;
    else if (wrap) mod_sh <= mod_i;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pwm_edge_unit #(.CNT_W(CNT_W), .MOD_W(MOD_W), .NUM_CH(NUM_CH)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .wrap_i     (wrap),
      .cnt_i      (cnt),
      .per_i      (per_sh),
      .rise_i     (rise_i[g*CNT_W +: CNT_W]),
      .fall_i     (fall_i[g*CNT_W +: CNT_W]),
      .cfg_i      (cfg_i[g*8 +: 8]),
      .mod_i      (mod_sh),
      .lvl_o      (lvl[g]),
      .rise_hit_o (rise_hit[g]),
      .fall_hit_o (fall_hit[g]),
      .gated_o    (gated[g]),
      .cfg_sh_o   (cfg_sh_flat[g*8 +: 8])
    );
  end

  assign pwm_o = lvl & ~pin_off_i & ~(gated & {NUM_OUT{~ss_done_i}});
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
  parameter int NUM_OUT = 8,
  parameter int CNT_W   = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wrap,
  input logic [CNT_W-1:0]     cnt,
  input logic [CNT_W-1:0]     per_sh,
  input logic [CNT_W-1:0]     period_i,
  input logic [NUM_OUT-1:0]   rise_hit,
  input logic [NUM_OUT-1:0]   fall_hit,
  input logic [NUM_OUT-1:0]   lvl,
  input logic [NUM_OUT-1:0]   pin_off_i,
  input logic                 ss_done_i,
  input logic [NUM_OUT*8-1:0] cfg_sh_flat,
  input logic [NUM_OUT-1:0]   pwm_o
);
  logic [NUM_OUT-1:0] c_gated;
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_m
    assign c_gated[g] = (cfg_sh_flat[g*8+6 -: 2] == 2'b10);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sh > CNT_W'(1)) |-> (cnt < per_sh)); // R1
  AST_CNT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sh <= CNT_W'(1)) |-> (cnt == '0)); // R1
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0) && (per_sh == $past(period_i))); // R9
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(per_sh) && $stable(cfg_sh_flat)); // R9
  AST_LVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_hit & ~fall_hit) != '0) |=> (($past(rise_hit & ~fall_hit) & ~lvl) == '0)); // R2
  AST_LVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_hit != '0) |=> (($past(fall_hit) & lvl) == '0)); // R2
  AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_hit | fall_hit) == '0) |=> $stable(lvl)); // R2
  AST_PIN_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_o & pin_off_i) == '0)); // R7
  AST_SS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done_i |-> ((pwm_o & c_gated) == '0)); // R8
endmodule

bind pwm_steer pwm_steer_chk #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wrap        (wrap),
  .cnt         (cnt),
  .per_sh      (per_sh),
  .period_i    (period_i),
  .rise_hit    (rise_hit),
  .fall_hit    (fall_hit),
  .lvl         (lvl),
  .pin_off_i   (pin_off_i),
  .ss_done_i   (ss_done_i),
  .cfg_sh_flat (cfg_sh_flat),
  .pwm_o       (pwm_o)
);

// File: tb/tb_pwm_steer.sv
`timescale 1ns/1ps
module tb_pwm_steer;
  localparam int NUM_OUT = 8;
  localparam int CNT_W   = 12;
  localparam int MOD_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0]         period_r = '0;
  logic [NUM_OUT*CNT_W-1:0] rise_r = '0, fall_r = '0;
  logic [NUM_OUT*8-1:0]     cfg_r = '0;
  logic [NUM_OUT-1:0]       pin_off_r = '0;
  logic [3*MOD_W-1:0]       mod_r = '0;
  logic                     ss_done_r = 1'b0;
  logic [NUM_OUT-1:0]       pwm_o;

  int    n_chk = 0, n_err = 0;
  bit    run_cmp = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  pwm_steer #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .MOD_W(MOD_W)) dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_r), .rise_i(rise_r), .fall_i(fall_r),
    .cfg_i(cfg_r), .pin_off_i(pin_off_r), .mod_i(mod_r), .ss_done_i(ss_done_r), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt, m_per;
  int m_rise[NUM_OUT], m_fall[NUM_OUT], m_cfg[NUM_OUT], m_mod[3];
  bit m_lvl[NUM_OUT];

  function automatic int eff(int base, int cfg, int m, int p, bit is_rise);
    int v, pm;
    bit en, sg;
    en = cfg[4] && (is_rise ? cfg[3] : cfg[1]);
    sg = is_rise ? cfg[2] : cfg[0];
    v  = base;
    if (en) v = sg ? v - m : v + m;
    if (v < 0) v = 0;
    if (cfg[7]) v += p / 2;
    pm = (p == 0) ? 1 : p;
    return v % pm;
  endfunction

  always @(posedge clk) begin
    bit w;
    int c, sel, re, fe;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0;
      for (int n = 0; n < NUM_OUT; n++) begin
        m_rise[n] = 0; m_fall[n] = 0; m_cfg[n] = 0; m_lvl[n] = 0;
      end
      for (int k = 0; k < 3; k++) m_mod[k] = 0;
    end else begin
      w = (m_per <= 1) || (m_cnt == m_per - 1);
      for (int n = 0; n < NUM_OUT; n++) begin
        sel = (m_cfg[n] >> 5) & 3;
        c   = (sel >= 2) ? 2 : sel;
        re  = eff(m_rise[n], m_cfg[n], m_mod[c], m_per, 1'b1);
        fe  = eff(m_fall[n], m_cfg[n], m_mod[c], m_per, 1'b0);
        if (m_cnt == fe)      m_lvl[n] = 0;
        else if (m_cnt == re) m_lvl[n] = 1;
      end
      if (w) begin
        m_cnt = 0;
        m_per = int'(period_r);
        for (int n = 0; n < NUM_OUT; n++) begin
          m_rise[n] = int'(rise_r[n*CNT_W +: CNT_W]);
          m_fall[n] = int'(fall_r[n*CNT_W +: CNT_W]);
          m_cfg[n]  = int'(cfg_r[n*8 +: 8]);
        end
        for (int k = 0; k < 3; k++) m_mod[k] = int'($signed(mod_r[k*MOD_W +: MOD_W]));
      end else begin
        m_cnt++;
      end
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    logic [NUM_OUT-1:0] e;
    #1;
    if (rst_n && run_cmp) begin
      for (int n = 0; n < NUM_OUT; n++)
        e[n] = m_lvl[n] && !pin_off_r[n] && !((((m_cfg[n] >> 5) & 3) == 2) && !ss_done_r);
      chk(cur_req, longint'(pwm_o), longint'(e));
    end
  end

  task automatic set_out(input int n, input int r, input int f, input int cfg);
    rise_r[n*CNT_W +: CNT_W] = CNT_W'(r);
    fall_r[n*CNT_W +: CNT_W] = CNT_W'(f);
    cfg_r[n*8 +: 8]          = 8'(cfg);
  endtask

  task automatic set_mod(input int a, input int b, input int c);
    mod_r = {MOD_W'(c), MOD_W'(b), MOD_W'(a)};
  endtask

  task automatic cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    time t0, t1;
    // R10: pins low under reset
    cycles(4);
    chk("R10", longint'(pwm_o), 0);
    period_r = 20;
    for (int n = 0; n < NUM_OUT; n++) set_out(n, n, n + 6, 0);
    cycles(2);
    chk("R10", longint'(pwm_o), 0);
    rst_n = 1'b1;
    run_cmp = 1;

    // R2: plain edges
    cur_req = "R2";
    cycles(50);

    // R1: rise-to-rise spacing equals the period
    cur_req = "R1";
    @(posedge pwm_o[2]); t0 = $time;
    @(posedge pwm_o[2]); t1 = $time;
    chk("R1", longint'((t1 - t0) / 4), 20);

    // R3: channel lanes and field decode
    cur_req = "R3";
    ss_done_r = 1'b1;
    set_mod(4, -3, 6);
    for (int n = 0; n < NUM_OUT; n++)
      set_out(n, 5, 12, ((n % 2) ? 8'h13 : 8'h18) | ((n % 4) << 5));
    cycles(60);

    // R4: direction and allow bit
    cur_req = "R4";
    set_mod(7, 2, -5);
    set_out(0, 8, 14, 8'h1C);
    set_out(1, 8, 14, 8'h0A);
    set_out(2, 8, 14, 8'h1B);
    set_out(3, 8, 14, 8'h3A);
    cycles(60);

    // R5: clamp at zero and wrap past the period end
    cur_req = "R5";
    set_mod(10, -9, 3);
    set_out(0, 2, 18, 8'h1E);
    set_out(1, 3, 15, 8'h3A);
    set_out(2, 19, 5, 8'h58);
    cycles(60);

    // R6: half-period shift
    cur_req = "R6";
    for (int n = 0; n < NUM_OUT; n++) set_out(n, 3, 8, 0);
    set_out(1, 3, 8, 8'h80);
    set_out(2, 15, 2, 8'h80);
    cycles(45);
    @(posedge pwm_o[0]); t0 = $time;
    @(posedge pwm_o[1]); t1 = $time;
    chk("R6", longint'((t1 - t0) / 4), 10);

    // R7: disable mask
    cur_req = "R7";
    pin_off_r = 8'h55; cycles(13);
    pin_off_r = 8'hAA; cycles(9);
    pin_off_r = 8'h00; cycles(20);

    // R8: soft-start gating of channel C
    cur_req = "R8";
    ss_done_r = 1'b0;
    for (int n = 0; n < NUM_OUT; n++) set_out(n, n, n + 7, (n % 2) ? 8'h60 : 8'h40);
    cycles(50);
    ss_done_r = 1'b1;
    cycles(30);

    // R9: mid-period changes wait for the restart
    cur_req = "R9";
    for (int k = 0; k < 6; k++) begin
      cycles(7);
      set_out(k, 2 + k, 11 + k, 8'h18 | (k << 5));
      set_mod(k, -k, 2 * k);
      period_r = CNT_W'(14 + k);
    end
    cycles(80);

    // R1: degenerate and short periods
    cur_req = "R1";
    period_r = 1;
    cycles(40);
    period_r = 7;
    for (int n = 0; n < NUM_OUT; n++) set_out(n, n % 7, (n + 3) % 7, 0);
    cycles(40);

    run_cmp = 0;
    cycles(2);
    finish_run();
  end
endmodule